// File: doc/BRIEF.md
# Push/pop register list sequencer

This block carries out the compressed stack save and restore macro-operations of a processor. A request gives an operation kind, a 4-bit code that names a list of registers, a signed stack adjustment and the current stack pointer value. The block checks the request and then moves the listed registers one per cycle between the register file and memory. It uses a plain request/ready memory port and places each register in its own word slot, counting down from the top of the frame.

When the transfers are done, the block writes the adjusted stack pointer back through its register-file write port. The zeroing variant then clears a0. The two return variants then raise a one-cycle return request that carries the value restored into ra.

A request whose list code is reserved, whose adjustment has the wrong sign, or whose adjustment is too small for the listed registers is refused. A refused request causes no memory traffic and no register write. Refusal is signalled by an illegal flag on the completion pulse.

Top module: `pushpop_seq`

## Requirements
- R1: A start with list code 0, 1, 2 or 3 ends one cycle later with done_o and illegal_o high together, with no memory request, no register write and no return request.
- R2: List code 4 moves only ra (x1) and code 5 moves ra and s0 (x8). Codes 6 to 14 move ra and s0 up to s(code-5), where s1 is x9 and s2..s9 are x18..x25. Code 15 moves ra and s0 up to s11 (x26, x27), so 13 registers in all.
- R3: Registers move in list order, ra first, with one transfer for each cycle in which mem_req_o and mem_ready_i are both high. Transfer k (from 0) uses address base - 4*(k+1). The base is the incoming stack pointer for push and the stack pointer plus the adjustment for the pop kinds.
- R4: While mem_req_o is high and mem_ready_i is low, the next cycle keeps mem_req_o high with the same address and write flag.
- R5: Operation code 0 (push) writes each listed register's value to memory (mem_we_o high). After the last transfer it writes the stack pointer plus the (negative) adjustment into x2.
- R6: The pop kinds (codes 1, 2, 3) read memory and write each word into its listed register in the cycle the word is accepted. After the last transfer they write the stack pointer plus the (positive) adjustment into x2. Register x0 is never written.
- R7: Operation code 3 writes zero into x10 in the cycle after the x2 write. Codes 2 and 3 raise ret_o for one cycle after their last register write, with ret_target_o equal to the value loaded into ra. done_o follows in the next cycle.
- R8: Codes 0 and 1 raise done_o in the cycle after the x2 write, with no write to x10 and no return request. done_o lasts one cycle and busy_o is low after it.
- R9: busy_o is low after reset and goes high in the cycle after an accepted start. It stays high up to and including the done_o cycle. A start seen while busy_o is high is ignored.
- R10: A push with a non-negative adjustment, a pop kind with a non-positive adjustment, or any adjustment whose magnitude is below 4 bytes times the list length is refused in the same way as R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken while idle |
| op_i | input | 2 | 0 push, 1 pop, 2 pop then return, 3 pop then zero a0 then return |
| list_code_i | input | 4 | Register list code |
| stack_adj_i | input | ADJ_W | Signed stack adjustment in bytes |
| sp_i | input | XLEN | Current stack pointer value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Request refused, valid with done_o |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a store |
| mem_addr_o | output | XLEN | Byte address of the slot |
| mem_wdata_o | output | XLEN | Store data |
| mem_rdata_i | input | XLEN | Load data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| rf_raddr_o | output | 5 | Register-file read index |
| rf_rdata_i | input | XLEN | Register-file read data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | XLEN | Register-file write data |
| ret_o | output | 1 | Return request pulse |
| ret_target_o | output | XLEN | Return address (restored ra) |

## Verification
The in-RTL assertions watch the properties that hold on every cycle. These are: a memory request always falls inside a busy period; a stalled request is held; a refused request stays silent; x0 is never written; a return is always followed by completion; busy never drops before done. Only the bench's scenarios can show the rest. That covers the exact list each code selects, the slot addresses, that the stored and restored data reach the right places, the final stack pointer, the order of the stack-pointer, a0 and return steps, and that a start issued mid-operation leaves no trace.

// File: rtl/pps_pkg.sv
package pps_pkg;

   typedef enum logic [1:0] {
      OP_PUSH     = 2'd0,
      OP_POP      = 2'd1,
      OP_POP_RET  = 2'd2,
      OP_POP_RETZ = 2'd3
   } pps_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_XFER,
      ST_SPWR,
      ST_ZERO,
      ST_RET,
      ST_DONE
   } pps_state_e;

   localparam int PPS_MAX_SLOTS = 13;
   localparam int PPS_SLOT_W    = $clog2(PPS_MAX_SLOTS + 1);
   localparam int PPS_RF_AW     = 5;
   localparam int PPS_CODES     = 16;
   localparam int PPS_FIRST_OK  = 4;

   localparam logic [PPS_RF_AW-1:0] REG_RA = 5'd1;
   localparam logic [PPS_RF_AW-1:0] REG_SP = 5'd2;
   localparam logic [PPS_RF_AW-1:0] REG_S0 = 5'd8;
   localparam logic [PPS_RF_AW-1:0] REG_A0 = 5'd10;
   localparam logic [PPS_RF_AW-1:0] REG_S2 = 5'd18;

endpackage

// File: rtl/pps_list_decode.sv
module pps_list_decode
   import pps_pkg::*;
#(
   parameter int SLOT_W = PPS_SLOT_W
)(
   input  logic [3:0]        code_i,
   output logic              legal_o,
   output logic [SLOT_W-1:0] count_o
);

   logic [SLOT_W-1:0]    cnt_tbl [PPS_CODES];
   logic [PPS_CODES-1:0] ok_vec;

   for (genvar c = 0; c < PPS_CODES; c++) begin : g_code
      if (c < PPS_FIRST_OK) begin : g_rsvd
         assign cnt_tbl[c] = '0;
         assign ok_vec[c]  = 1'b0;
      end else if (c == PPS_CODES - 1) begin : g_top
         assign cnt_tbl[c] = SLOT_W'(PPS_MAX_SLOTS);
         assign ok_vec[c]  = 1'b1;
      end else begin : g_lin
         assign cnt_tbl[c] = SLOT_W'(c - 3);
         assign ok_vec[c]  = 1'b1;
      end
   end

   assign legal_o = ok_vec[code_i];
   assign count_o = cnt_tbl[code_i];

endmodule

// File: rtl/pps_slot_map.sv
module pps_slot_map
   import pps_pkg::*;
#(
   parameter int SLOT_W = PPS_SLOT_W
)(
   input  logic [SLOT_W-1:0]    slot_i,
   output logic [PPS_RF_AW-1:0] reg_o
);

   logic [PPS_RF_AW-1:0] map_tbl [PPS_MAX_SLOTS];

   for (genvar k = 0; k < PPS_MAX_SLOTS; k++) begin : g_slot
      if (k == 0) begin : g_ra
         assign map_tbl[k] = REG_RA;
      end else if (k < 3) begin : g_low
         assign map_tbl[k] = REG_S0 + PPS_RF_AW'(k - 1);
      end else begin : g_high
         assign map_tbl[k] = REG_S2 + PPS_RF_AW'(k - 3);
      end
   end

   assign reg_o = (32'(slot_i) < PPS_MAX_SLOTS) ? map_tbl[slot_i] : REG_RA;

endmodule

// File: rtl/pps_adj_check.sv
module pps_adj_check
   import pps_pkg::*;
#(
   parameter int ADJ_W       = 12,
   parameter int SLOT_W      = PPS_SLOT_W,
   parameter int SLOT_SH     = 2,
   parameter bit CHECK_FRAME = 1'b1
)(
   input  logic [1:0]        op_i,
   input  logic [ADJ_W-1:0]  adj_i,
   input  logic [SLOT_W-1:0] count_i,
   output logic              ok_o
);

   logic is_push;
   logic neg;
   logic sign_ok;

   assign is_push = (op_i == OP_PUSH);
   assign neg     = adj_i[ADJ_W-1];
   assign sign_ok = is_push ? neg : (!neg && (adj_i != '0));

   if (CHECK_FRAME) begin : g_frame
      logic [ADJ_W:0] ext;
      logic [ADJ_W:0] mag;
      logic [ADJ_W:0] need;
      assign ext  = {adj_i[ADJ_W-1], adj_i};
      assign mag  = neg ? (~ext + 1'b1) : ext;
      assign need = (ADJ_W+1)'(count_i) << SLOT_SH;
      assign ok_o = sign_ok && (mag >= need);
   end else begin : g_sign_only
      logic unused_cnt;
      assign unused_cnt = ^count_i;
      assign ok_o = sign_ok;
   end

endmodule

// File: rtl/pushpop_seq.sv
module pushpop_seq
   import pps_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int ADJ_W       = 12,
   parameter bit CHECK_FRAME = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [1:0]           op_i,
   input  logic [3:0]           list_code_i,
   input  logic [ADJ_W-1:0]     stack_adj_i,
   input  logic [XLEN-1:0]      sp_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 illegal_o,
   output logic                 mem_req_o,
   output logic                 mem_we_o,
   output logic [XLEN-1:0]      mem_addr_o,
   output logic [XLEN-1:0]      mem_wdata_o,
   input  logic [XLEN-1:0]      mem_rdata_i,
   input  logic                 mem_ready_i,
   output logic [PPS_RF_AW-1:0] rf_raddr_o,
   input  logic [XLEN-1:0]      rf_rdata_i,
   output logic                 rf_we_o,
   output logic [PPS_RF_AW-1:0] rf_waddr_o,
   output logic [XLEN-1:0]      rf_wdata_o,
   output logic                 ret_o,
   output logic [XLEN-1:0]      ret_target_o
);

   localparam int SLOT_BYTES = XLEN / 8;
   localparam int SLOT_SH    = $clog2(SLOT_BYTES);
   localparam int SLOT_W     = PPS_SLOT_W;

   if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
      $error("pushpop_seq: XLEN must be 32 or 64");
   end
   if (ADJ_W >= XLEN || ADJ_W < 8) begin : g_bad_adj
      $error("pushpop_seq: ADJ_W must lie in 8..XLEN-1");
   end

   pps_state_e        state_q;
   pps_op_e           op_q;
   logic [SLOT_W-1:0] cnt_q;
   logic [SLOT_W-1:0] slot_q;
   logic [XLEN-1:0]   base_q;
   logic [XLEN-1:0]   newsp_q;
   logic [XLEN-1:0]   ra_q;
   logic              illegal_q;

   logic              list_ok;
   logic [SLOT_W-1:0] list_cnt;
   logic              adj_ok;
   logic [XLEN-1:0]   adj_ext;
   logic [XLEN-1:0]   slot_off;
   logic [PPS_RF_AW-1:0] slot_reg;
   logic              is_push_q;
   logic              last_slot;
   logic              accept;

   pps_list_decode #(.SLOT_W(SLOT_W)) u_list (
      .code_i  (list_code_i),
      .legal_o (list_ok),
      .count_o (list_cnt)
   );

   pps_adj_check #(
      .ADJ_W       (ADJ_W),
      .SLOT_W      (SLOT_W),
      .SLOT_SH     (SLOT_SH),
      .CHECK_FRAME (CHECK_FRAME)
   ) u_adj (
      .op_i    (op_i),
      .adj_i   (stack_adj_i),
      .count_i (list_cnt),
      .ok_o    (adj_ok)
   );

   pps_slot_map #(.SLOT_W(SLOT_W)) u_map (
      .slot_i (slot_q),
      .reg_o  (slot_reg)
   );

   assign adj_ext   = {{(XLEN-ADJ_W){stack_adj_i[ADJ_W-1]}}, stack_adj_i};
   assign slot_off  = XLEN'(32'(slot_q) + 32'd1) << SLOT_SH;
   assign is_push_q = (op_q == OP_PUSH);
   assign last_slot = (slot_q == cnt_q - SLOT_W'(1));
   assign accept    = start_i && (state_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         op_q      <= OP_PUSH;
         cnt_q     <= '0;
         slot_q    <= '0;
         base_q    <= '0;
         newsp_q   <= '0;
         ra_q      <= '0;
         illegal_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  op_q    <= pps_op_e'(op_i);
                  cnt_q   <= list_cnt;
                  slot_q  <= '0;
                  newsp_q <= sp_i + adj_ext;
                  base_q  <= (op_i == OP_PUSH) ? sp_i : (sp_i + adj_ext);
                  if (list_ok && adj_ok) begin
                     illegal_q <= 1'b0;
                     state_q   <= ST_XFER;
                  end else begin
                     illegal_q <= 1'b1;
                     state_q   <= ST_DONE;
                  end
               end
            end
            ST_XFER: begin
               if (mem_ready_i) begin
                  if (!is_push_q && slot_q == '0) begin
                     ra_q <= mem_rdata_i;
                  end
                  if (last_slot) begin
                     state_q <= ST_SPWR;
                  end else begin
                     slot_q <= slot_q + SLOT_W'(1);
                  end
               end
            end
            ST_SPWR: begin
               case (op_q)
                  OP_POP_RETZ: state_q <= ST_ZERO;
                  OP_POP_RET:  state_q <= ST_RET;
                  default:     state_q <= ST_DONE;
               endcase
            end
            ST_ZERO: state_q <= ST_RET;
            ST_RET:  state_q <= ST_DONE;
            ST_DONE: begin
               illegal_q <= 1'b0;
               state_q   <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = (state_q == ST_DONE);
   assign illegal_o   = done_o && illegal_q;
   assign mem_req_o   = (state_q == ST_XFER);
   assign mem_we_o    = mem_req_o && is_push_q;
   assign mem_addr_o  = base_q - slot_off;
   assign mem_wdata_o = mem_we_o ? rf_rdata_i : '0;
   assign rf_raddr_o  = slot_reg;
   assign ret_o       = (state_q == ST_RET);
   assign ret_target_o = ra_q;

   always_comb begin
      rf_we_o    = 1'b0;
      rf_waddr_o = '0;
      rf_wdata_o = '0;
      case (state_q)
         ST_XFER: begin
            if (!is_push_q && mem_ready_i) begin
               rf_we_o    = 1'b1;
               rf_waddr_o = slot_reg;
               rf_wdata_o = mem_rdata_i;
            end
         end
         ST_SPWR: begin
            rf_we_o    = 1'b1;
            rf_waddr_o = REG_SP;
            rf_wdata_o = newsp_q;
         end
         ST_ZERO: begin
            rf_we_o    = 1'b1;
            rf_waddr_o = REG_A0;
         end
         default: ;
      endcase
   end

   assert_req_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> busy_o);

   assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

   assert_refused_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (done_o && !mem_req_o && !rf_we_o && !ret_o));

   assert_no_x0_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> (rf_waddr_o != '0));

   assert_ret_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ret_o |=> (done_o && !ret_o));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

endmodule

// File: tb/pushpop_seq_bench.sv
module pushpop_seq_bench;

   localparam int PERIOD = 10;
   localparam int XLEN   = 32;
   localparam int ADJ_W  = 12;
   localparam logic [31:0] SP0 = 32'h0000_0300;

   typedef struct packed {
      logic [1:0]  op;
      logic [3:0]  code;
      logic [11:0] adj;
      logic        stall;
      logic        ill;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 4'd4,  12'hFF0, 1'b0, 1'b0},
      '{2'd0, 4'd15, 12'hFC0, 1'b1, 1'b0},
      '{2'd1, 4'd5,  12'h010, 1'b0, 1'b0},
      '{2'd1, 4'd14, 12'h030, 1'b1, 1'b0},
      '{2'd2, 4'd7,  12'h010, 1'b0, 1'b0},
      '{2'd3, 4'd15, 12'h040, 1'b1, 1'b0},
      '{2'd3, 4'd4,  12'h010, 1'b0, 1'b0},
      '{2'd0, 4'd2,  12'hFF0, 1'b0, 1'b1},
      '{2'd1, 4'd0,  12'h010, 1'b0, 1'b1},
      '{2'd0, 4'd6,  12'h010, 1'b0, 1'b1},
      '{2'd1, 4'd6,  12'hFF0, 1'b0, 1'b1},
      '{2'd1, 4'd10, 12'h010, 1'b0, 1'b1},
      '{2'd0, 4'd9,  12'hFE8, 1'b1, 1'b0},
      '{2'd2, 4'd4,  12'h000, 1'b0, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [1:0] op_i = '0;
   logic [3:0] list_code_i = '0;
   logic [ADJ_W-1:0] stack_adj_i = '0;
   logic [XLEN-1:0] sp_i = '0;
   logic busy_o, done_o, illegal_o;
   logic mem_req_o, mem_we_o;
   logic [XLEN-1:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
   logic mem_ready_i = 1'b0;
   logic [4:0] rf_raddr_o, rf_waddr_o;
   logic [XLEN-1:0] rf_rdata_i, rf_wdata_o;
   logic rf_we_o, ret_o;
   logic [XLEN-1:0] ret_target_o;

   logic [31:0] rf_m  [32];
   logic [31:0] mem_m [256];
   logic [31:0] init_rf  [32];
   logic [31:0] init_mem [256];
   logic [31:0] exp_rf  [32];
   logic [31:0] exp_mem [256];

   int checks = 0;
   int fails  = 0;

   assign rf_rdata_i  = rf_m[rf_raddr_o];
   assign mem_rdata_i = mem_m[mem_addr_o[9:2]];

   always #(PERIOD/2) clk = ~clk;

   pushpop_seq #(.XLEN(XLEN), .ADJ_W(ADJ_W)) u_pushpop_seq (
      .clk, .rst_n, .start_i, .op_i, .list_code_i, .stack_adj_i, .sp_i,
      .busy_o, .done_o, .illegal_o, .mem_req_o, .mem_we_o, .mem_addr_o,
      .mem_wdata_o, .mem_rdata_i, .mem_ready_i, .rf_raddr_o, .rf_rdata_i,
      .rf_we_o, .rf_waddr_o, .rf_wdata_o, .ret_o, .ret_target_o
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // list length per code (R2)
   function automatic int list_len(input int code);
      if (code < 4) return 0;
      if (code == 15) return 13;
      return code - 3;
   endfunction

   // register number of list entry k (R2)
   function automatic int entry_reg(input int k);
      if (k == 0) return 1;
      if (k == 1) return 8;
      if (k == 2) return 9;
      return k + 15;
   endfunction

   task automatic run_vec(input int vi, input vec_t v, input int poke);
      int adj, n, base, hs_n, addr_err, data_err, stall_err, x0_err;
      int wr_n, ret_n, cyc_sp, cyc_a0, cyc_ret, cyc_done, busy_gap, mism;
      logic [31:0] ret_val, prev_addr;
      logic prev_stall, prev_we, ill_seen;
      adj  = $signed(v.adj);
      n    = list_len(int'(v.code));
      base = (v.op == 2'd0) ? int'(SP0) : int'(SP0) + adj;
      for (int r = 0; r < 32; r++) rf_m[r] = 32'h1000_0000 + (vi << 16) + r;
      rf_m[0] = '0;
      rf_m[2] = SP0;
      for (int w = 0; w < 256; w++) mem_m[w] = 32'hC000_0000 + (vi << 12) + w;
      for (int r = 0; r < 32; r++) begin init_rf[r] = rf_m[r]; exp_rf[r] = rf_m[r]; end
      for (int w = 0; w < 256; w++) begin init_mem[w] = mem_m[w]; exp_mem[w] = mem_m[w]; end
      if (!v.ill) begin
         for (int k = 0; k < n; k++) begin
            if (v.op == 2'd0) exp_mem[((base - 4*(k+1)) >> 2) & 255] = init_rf[entry_reg(k)];
            else exp_rf[entry_reg(k)] = init_mem[((base - 4*(k+1)) >> 2) & 255];
         end
         exp_rf[2] = SP0 + adj;
         if (v.op == 2'd3) exp_rf[10] = '0;
      end
      hs_n = 0; addr_err = 0; data_err = 0; stall_err = 0; x0_err = 0;
      wr_n = 0; ret_n = 0; cyc_sp = -1; cyc_a0 = -1; cyc_ret = -1; cyc_done = -1;
      busy_gap = 0; ret_val = '0; prev_stall = 0; prev_addr = '0; prev_we = 0; ill_seen = 0;
      @(negedge clk);
      start_i = 1'b1; op_i = v.op; list_code_i = v.code; stack_adj_i = v.adj; sp_i = SP0;
      @(negedge clk);
      start_i = 1'b0;
      for (int cyc = 0; cyc < 200; cyc++) begin
         if (cyc > 0) @(negedge clk);
         start_i = (cyc == poke);
         if (cyc == poke) begin op_i = 2'd1; list_code_i = 4'd4; stack_adj_i = 12'h010; end
         mem_ready_i = v.stall ? cyc[0] : 1'b1;
         #1;
         if (!busy_o) busy_gap++;
         if (prev_stall && (!mem_req_o || mem_addr_o != prev_addr || mem_we_o != prev_we)) stall_err++;
         prev_stall = mem_req_o && !mem_ready_i;
         prev_addr  = mem_addr_o;
         prev_we    = mem_we_o;
         if (mem_req_o && mem_ready_i) begin
            if (mem_addr_o != 32'(base - 4*(hs_n+1)) || mem_we_o != (v.op == 2'd0)) addr_err++;
            if (mem_we_o) begin
               if (mem_wdata_o != init_rf[entry_reg(hs_n)]) data_err++;
               mem_m[mem_addr_o[9:2]] = mem_wdata_o;
            end
            hs_n++;
         end
         if (rf_we_o) begin
            wr_n++;
            if (rf_waddr_o == 5'd0) x0_err++;
            else rf_m[rf_waddr_o] = rf_wdata_o;
            if (rf_waddr_o == 5'd2) cyc_sp = cyc;
            if (rf_waddr_o == 5'd10 && !mem_req_o) cyc_a0 = cyc;
         end
         if (ret_o) begin ret_n++; cyc_ret = cyc; ret_val = ret_target_o; end
         if (done_o) begin cyc_done = cyc; ill_seen = illegal_o; break; end
      end
      start_i = 1'b0;
      check(cyc_done >= 0, "R9 operation completes", 32'(cyc_done), 32'd0);
      check(ill_seen == v.ill, v.ill ? "R1/R10 refused flag" : "R10 accepted flag", 32'(ill_seen), 32'(v.ill));
      check(busy_gap == 0, "R9 busy held until done", 32'(busy_gap), 32'd0);
      if (v.ill) begin
         check(hs_n == 0 && wr_n == 0 && ret_n == 0, "R1 refused without traffic",
               32'(hs_n + wr_n + ret_n), 32'd0);
         check(cyc_done == 0, "R1 refusal one cycle after start", 32'(cyc_done), 32'd0);
      end else begin
         check(hs_n == n, "R2 transfer count", 32'(hs_n), 32'(n));
         check(addr_err == 0, "R3 slot address order", 32'(addr_err), 32'd0);
         check(stall_err == 0, "R4 stalled request held", 32'(stall_err), 32'd0);
         check(x0_err == 0, "R6 x0 untouched", 32'(x0_err), 32'd0);
         check(rf_m[2] == exp_rf[2], "R5/R6 stack pointer", rf_m[2], exp_rf[2]);
         if (v.op == 2'd0) begin
            mism = data_err;
            for (int w = 0; w < 256; w++) if (mem_m[w] != exp_mem[w]) mism++;
            check(mism == 0, "R5 pushed words", 32'(mism), 32'd0);
         end else begin
            mism = 0;
            for (int r = 0; r < 32; r++) if (rf_m[r] != exp_rf[r]) mism++;
            check(mism == 0, "R6 restored registers", 32'(mism), 32'd0);
         end
         if (v.op >= 2'd2) begin
            check(ret_n == 1 && ret_val == exp_rf[1], "R7 return target", ret_val, exp_rf[1]);
            check(cyc_done == cyc_ret + 1, "R7 done after return", 32'(cyc_done), 32'(cyc_ret + 1));
            if (v.op == 2'd3)
               check(cyc_a0 == cyc_sp + 1 && cyc_ret == cyc_a0 + 1, "R7 sp, a0, return order",
                     32'(cyc_a0), 32'(cyc_sp + 1));
            else
               check(cyc_ret == cyc_sp + 1 && rf_m[10] == init_rf[10], "R7 no a0 write on plain return",
                     rf_m[10], init_rf[10]);
         end else begin
            check(ret_n == 0 && rf_m[10] == init_rf[10], "R8 no return, a0 kept", 32'(ret_n), 32'd0);
            check(cyc_done == cyc_sp + 1, "R8 done after sp write", 32'(cyc_done), 32'(cyc_sp + 1));
         end
      end
      @(negedge clk);
      #1;
      check(!busy_o && !mem_req_o, "R8/R9 idle after done", 32'(busy_o), 32'd0);
   endtask

   initial begin
      #(PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int r = 0; r < 32; r++) rf_m[r] = '0;
      for (int w = 0; w < 256; w++) mem_m[w] = '0;
      repeat (3) @(negedge clk);
      #1;
      check(!busy_o && !done_o && !mem_req_o && !rf_we_o && !ret_o && !illegal_o,
            "R9 reset state", {26'd0, busy_o, done_o, mem_req_o, rf_we_o, ret_o, illegal_o}, 32'd0);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) run_vec(i, VECS[i], -1);
      // R9: start raised mid-operation is ignored
      run_vec(NV, VECS[1], 3);
      @(negedge clk);
      #1;
      check(!busy_o, "R9 mid-run start not queued", 32'(busy_o), 32'd0);
      // R2: top code boundary with stalls on a pop kind
      run_vec(NV + 1, '{2'd1, 4'd15, 12'h034, 1'b1, 1'b0}, -1);
      // R10: frame one slot short of the list
      run_vec(NV + 2, '{2'd0, 4'd15, 12'hFD0, 1'b0, 1'b1}, -1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule